// File: doc/BRIEF.md
# Aggregated Receive Status Walker

This block walks one aggregated receive buffer held in a word-addressed memory. The buffer is a chain of 32-byte status records, and each accepted record is followed directly by the payload it describes. After a start pulse the walker fetches each record and pulls out its opcode, exception, tag mask, length, source endpoint, metadata and routing rule index. It then decides whether to skip the record or to report a descriptor, and if it reports one, whether the packet is kept or dropped. Each descriptor carries the byte offset of the payload in the buffer, the length, the source, the metadata and a keep flag.

After each record the walker moves forward to the next one. A skipped record advances it by the status size alone. A reported record advances it by the status, plus the payload rounded up to the pad alignment, plus a checksum trailer when checksum offload is enabled. Records may start at any byte, so the walker realigns the words it reads. The walk ends when fewer bytes remain than one status record holds. It also ends, with an overrun flag, when a record claims more bytes than remain. Tagged records produce a completion pulse when they came from the command endpoint and an error pulse otherwise.

Top module: `rx_status_walker`

## Requirements
- R1: After reset, `busy`, `rd_en`, `desc_valid`, `tag_done`, `tag_err`, `overrun` and `done` are all low.
- R2: Word 0 of a record (little-endian, 4 bytes each) is {tag[31:16], exception[15:8], opcode[7:0]}. Word 1 holds the length in bits 15:0. The source is bits 20:16 when `wide_src`=0 and bits 23:16 when `wide_src`=1. Word 2 is the metadata. `desc_len`, `desc_src` and `desc_meta` report these values.
- R3: `desc_off` is the byte offset of the record start plus 32.
- R4: A reported record advances the walk by 32 + roundup(length, A) + (`csum_en` ? TRAIL_BYTES (default 8) : 0). A is `pad_align`, or 1 when `pad_align` is 0. `pad_align` must be 0 or a power of two.
- R5: A record with length 0 produces no descriptor and advances the walk by 32 bytes.
- R6: Only opcodes 0x01, 0x04, 0x08 and 0x40 are parsed. A record with any other opcode produces no descriptor and advances by 32 bytes.
- R7: A reported record with a non-zero tag mask has `desc_keep`=0. In the same cycle as its descriptor, `tag_done` pulses if its source equals `cmd_ep`, and `tag_err` pulses otherwise. The two are never high together.
- R8: For an untagged record with a non-zero exception, `desc_keep`=0 exactly when the exception equals DEAGG_EXC (default 0x04). The rule index is not consulted.
- R9: For an untagged record with exception 0, `desc_keep`=0 exactly when the rule index (word 3 bits 31:22) equals MISS_RULE (default 0x3FF).
- R10: The walk ends with a `done` pulse when fewer than 32 bytes remain. Trailing bytes are ignored, and no read goes past word `total_len/4`.
- R11: A record whose advance exceeds the remaining bytes produces no descriptor. It raises `overrun` together with `done` and ends the walk.
- R12: While `busy` is high, `start`, `total_len` and the configuration inputs are ignored. The configuration is captured at the accepted start.
- R13: `desc_valid`, `tag_done`, `tag_err`, `overrun` and `done` are single-cycle pulses. `desc_valid` never coincides with `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk when idle |
| total_len | input | LEN_W | Received bytes in the buffer |
| pad_align | input | 8 | Payload alignment, 0 meaning 1 |
| csum_en | input | 1 | Checksum trailer follows each payload |
| wide_src | input | 1 | Select the 8-bit source field layout |
| cmd_ep | input | 8 | Command endpoint id |
| rd_en | output | 1 | Buffer read request |
| rd_addr | output | LEN_W-2 | Buffer word address |
| rd_data | input | 32 | Read data, one cycle after the request |
| busy | output | 1 | Walk in progress |
| desc_valid | output | 1 | Descriptor pulse |
| desc_off | output | LEN_W | Payload byte offset |
| desc_len | output | 16 | Payload length |
| desc_src | output | 8 | Source endpoint |
| desc_meta | output | 32 | Metadata word |
| desc_keep | output | 1 | Deliver (1) or drop (0) |
| tag_done | output | 1 | Tagged record from the command endpoint |
| tag_err | output | 1 | Tagged record from another endpoint |
| overrun | output | 1 | Record runs past the buffer end |
| done | output | 1 | Walk finished |

## Verification
On every cycle, the assertions check the pulse relations. Tag pulses must come only with a dropped descriptor and never both at once. An overrun must come with `done`, and `done` never repeats. Reads must stay inside the buffer and only while busy. The advance arithmetic, the byte realignment, the field layouts and the keep decision can only be shown by scenarios. In those, the bench builds buffers with known strides, alignments, opcodes, tags and exceptions. It then compares every descriptor and pulse count against its own walk of the same bytes.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  localparam int STAT_BYTES = 32;
  localparam int WIN_WORDS  = 9;

  localparam logic [7:0] OP_PKT    = 8'h01;
  localparam logic [7:0] OP_DROPPED = 8'h04;
  localparam logic [7:0] OP_SUSP   = 8'h08;
  localparam logic [7:0] OP_PASS2  = 8'h40;

  typedef struct packed {
    logic [7:0]  op;
    logic [7:0]  exc;
    logic [15:0] tag;
    logic [15:0] len;
    logic [7:0]  src;
    logic [31:0] meta;
    logic [9:0]  rule;
  } rec_t;

  // opcode classes sharing the packet record layout
  function automatic logic opcode_ok(logic [7:0] op);
    return (op == OP_PKT) || (op == OP_DROPPED) || (op == OP_SUSP) || (op == OP_PASS2);
  endfunction

  // round a length up to a power-of-two alignment, zero meaning one
  function automatic logic [31:0] pad_up(logic [31:0] len, logic [7:0] align);
    logic [31:0] a;
    a = (align == 8'd0) ? 32'd1 : {24'd0, align};
    return (len + a - 32'd1) & ~(a - 32'd1);
  endfunction

  function automatic logic [31:0] stride_of(logic [15:0] len, logic [7:0] align,
                                            logic csum, logic [31:0] trail);
    return 32'(STAT_BYTES) + pad_up({16'd0, len}, align) + (csum ? trail : 32'd0);
  endfunction
endpackage

// File: rtl/rsw_fetch.sv
module rsw_fetch
  import rsw_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic [ADDR_W-1:0]        base_word,
  output logic                     rd_en,
  output logic [ADDR_W-1:0]        rd_addr,
  input  logic [31:0]              rd_data,
  output logic [32*WIN_WORDS-1:0]  win,
  output logic                     win_ok
);
  localparam int CNT_W = $clog2(WIN_WORDS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_WORDS);

  logic              act;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] base_q;

  assign rd_en   = act && (cnt < LAST);
  assign rd_addr = base_q + ADDR_W'(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      cnt    <= '0;
      base_q <= '0;
      win    <= '0;
      win_ok <= 1'b0;
    end else begin
      win_ok <= 1'b0;
      if (go) begin
        act    <= 1'b1;
        cnt    <= '0;
        base_q <= base_word;
      end else if (act) begin
        if (cnt != '0) win[32*(int'(cnt)-1) +: 32] <= rd_data;
        if (cnt == LAST) begin
          act    <= 1'b0;
          win_ok <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R13
  win_single_chk: assert property (@(posedge clk) disable iff (!rst_n) win_ok |=> !win_ok);
  // R10
  go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) go |-> !act);
endmodule

// File: rtl/rsw_decode.sv
module rsw_decode
  import rsw_pkg::*;
#(
  parameter logic [7:0]  DEAGG_EXC   = 8'h04,
  parameter logic [9:0]  MISS_RULE   = 10'h3FF,
  parameter int          TRAIL_BYTES = 8
) (
  input  logic [32*WIN_WORDS-1:0] win,
  input  logic [1:0]              lane,
  input  logic                    wide_src,
  input  logic [7:0]              pad_align,
  input  logic                    csum_en,
  input  logic [7:0]              cmd_ep,
  output rec_t                    rec,
  output logic                    skip,
  output logic                    keep,
  output logic                    tag_hit,
  output logic                    tag_cmd,
  output logic [31:0]             stride
);
  logic [32*WIN_WORDS-1:0] shifted;
  logic [255:0]            recw;
  logic [31:0]             w0, w1, w2, w3;
  logic                    unused_bits;

  // realign the record to the byte where it starts
  assign shifted = win >> {lane, 3'b000};
  assign recw    = shifted[255:0];
  assign w0 = recw[31:0];
  assign w1 = recw[63:32];
  assign w2 = recw[95:64];
  assign w3 = recw[127:96];

  always_comb begin
    rec.op   = w0[7:0];
    rec.exc  = w0[15:8];
    rec.tag  = w0[31:16];
    rec.len  = w1[15:0];
    rec.src  = wide_src ? w1[23:16] : {3'b000, w1[20:16]};
    rec.meta = w2;
    rec.rule = w3[31:22];
  end

  assign skip    = (rec.len == 16'd0) || !opcode_ok(rec.op);
  assign tag_hit = (rec.tag != 16'd0);
  assign tag_cmd = (rec.src == cmd_ep);
  assign stride  = skip ? 32'(STAT_BYTES)
                        : stride_of(rec.len, pad_align, csum_en, 32'(TRAIL_BYTES));

  always_comb begin
    if (tag_hit)              keep = 1'b0;
    else if (rec.exc != 8'd0) keep = (rec.exc != DEAGG_EXC);
    else                      keep = (rec.rule != MISS_RULE);
  end

  assign unused_bits = ^{shifted[32*WIN_WORDS-1:256], recw[255:128], w1[31:24], w3[21:0]};
endmodule

// File: rtl/rx_status_walker.sv
module rx_status_walker
  import rsw_pkg::*;
#(
  parameter int          LEN_W       = 16,
  parameter int          TRAIL_BYTES = 8,
  parameter logic [7:0]  DEAGG_EXC   = 8'h04,
  parameter logic [9:0]  MISS_RULE   = 10'h3FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  total_len,
  input  logic [7:0]        pad_align,
  input  logic              csum_en,
  input  logic              wide_src,
  input  logic [7:0]        cmd_ep,
  output logic              rd_en,
  output logic [LEN_W-3:0]  rd_addr,
  input  logic [31:0]       rd_data,
  output logic              busy,
  output logic              desc_valid,
  output logic [LEN_W-1:0]  desc_off,
  output logic [15:0]       desc_len,
  output logic [7:0]        desc_src,
  output logic [31:0]       desc_meta,
  output logic              desc_keep,
  output logic              tag_done,
  output logic              tag_err,
  output logic              overrun,
  output logic              done
);
  localparam int ADDR_W = LEN_W - 2;
  localparam logic [LEN_W-1:0] STAT_L = LEN_W'(STAT_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_FETCH} st_t;
  st_t st;

  logic [LEN_W-1:0] total_q, off_q, rem_q;
  logic [7:0]       align_q, cmd_q;
  logic             csum_q, wide_q;

  logic                    fetch_go, win_ok;
  logic [32*WIN_WORDS-1:0] win;
  rec_t                    rec;
  logic                    skip, keep, tag_hit, tag_cmd;
  logic [31:0]             stride;
  logic                    too_long;

  assign busy     = (st != S_IDLE);
  assign fetch_go = (st == S_CHECK) && (rem_q >= STAT_L);
  assign too_long = stride > 32'(rem_q);

  rsw_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(fetch_go), .base_word(off_q[LEN_W-1:2]),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .win(win), .win_ok(win_ok)
  );

  rsw_decode #(.DEAGG_EXC(DEAGG_EXC), .MISS_RULE(MISS_RULE), .TRAIL_BYTES(TRAIL_BYTES)) u_dec (
    .win(win), .lane(off_q[1:0]), .wide_src(wide_q), .pad_align(align_q),
    .csum_en(csum_q), .cmd_ep(cmd_q), .rec(rec), .skip(skip), .keep(keep),
    .tag_hit(tag_hit), .tag_cmd(tag_cmd), .stride(stride)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      total_q <= '0; off_q <= '0; rem_q <= '0;
      align_q <= '0; cmd_q <= '0; csum_q <= 1'b0; wide_q <= 1'b0;
      desc_valid <= 1'b0; desc_off <= '0; desc_len <= '0; desc_src <= '0;
      desc_meta <= '0; desc_keep <= 1'b0;
      tag_done <= 1'b0; tag_err <= 1'b0; overrun <= 1'b0; done <= 1'b0;
    end else begin
      desc_valid <= 1'b0;
      tag_done   <= 1'b0;
      tag_err    <= 1'b0;
      overrun    <= 1'b0;
      done       <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          total_q <= total_len;
          rem_q   <= total_len;
          off_q   <= '0;
          align_q <= pad_align;
          csum_q  <= csum_en;
          wide_q  <= wide_src;
          cmd_q   <= cmd_ep;
          st      <= S_CHECK;
        end
        S_CHECK: begin
          if (rem_q < STAT_L) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            st <= S_FETCH;
          end
        end
        S_FETCH: if (win_ok) begin
          if (skip) begin
            off_q <= off_q + STAT_L;
            rem_q <= rem_q - STAT_L;
            st    <= S_CHECK;
          end else if (too_long) begin
            overrun <= 1'b1;
            done    <= 1'b1;
            st      <= S_IDLE;
          end else begin
            desc_valid <= 1'b1;
            desc_off   <= off_q + STAT_L;
            desc_len   <= rec.len;
            desc_src   <= rec.src;
            desc_meta  <= rec.meta;
            desc_keep  <= keep;
            tag_done   <= tag_hit && tag_cmd;
            tag_err    <= tag_hit && !tag_cmd;
            off_q      <= off_q + stride[LEN_W-1:0];
            rem_q      <= rem_q - stride[LEN_W-1:0];
            st         <= S_CHECK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R13
  desc_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n) desc_valid |-> !overrun);
  // R7
  tag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({tag_done, tag_err}));
  // R7
  tag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_done || tag_err) |-> (desc_valid && !desc_keep));
  // R11
  ovr_end_chk: assert property (@(posedge clk) disable iff (!rst_n) overrun |-> done);
  // R13
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  read_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr <= total_q[LEN_W-1:2]));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !rd_en);
endmodule

// File: tb/rx_status_walker_test.sv
module rx_status_walker_test;
  localparam int LEN_W = 16;
  localparam int MEMB  = 2048;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LEN_W-1:0] total_len = '0;
  logic [7:0] pad_align = '0, cmd_ep = '0;
  logic csum_en = 1'b0, wide_src = 1'b0;
  logic rd_en; logic [LEN_W-3:0] rd_addr; logic [31:0] rd_data = '0;
  logic busy, desc_valid, desc_keep, tag_done, tag_err, overrun, done;
  logic [LEN_W-1:0] desc_off; logic [15:0] desc_len; logic [7:0] desc_src; logic [31:0] desc_meta;

  always #4 clk = ~clk;

  rx_status_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len), .pad_align(pad_align),
    .csum_en(csum_en), .wide_src(wide_src), .cmd_ep(cmd_ep), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .desc_valid(desc_valid), .desc_off(desc_off),
    .desc_len(desc_len), .desc_src(desc_src), .desc_meta(desc_meta), .desc_keep(desc_keep),
    .tag_done(tag_done), .tag_err(tag_err), .overrun(overrun), .done(done)
  );

  logic [7:0] mem [MEMB];
  int nrun = 0, nfail = 0, cycles = 0;

  // configuration the bench model uses
  int cfg_align; bit cfg_csum, cfg_wide; logic [7:0] cfg_cmd;
  int wp;

  // expected and observed results
  int e_n, e_td, e_te, e_ov;
  int e_off[64], e_len[64], e_src[64], e_keep[64]; logic [31:0] e_meta[64];
  int g_n, g_td, g_te, g_ov; bit g_done;
  int g_off[64], g_len[64], g_src[64], g_keep[64]; logic [31:0] g_meta[64];

  always @(posedge clk) begin
    int a;
    a = 4 * int'(rd_addr);
    if (rd_en) rd_data <= (a + 3 < MEMB) ? {mem[a+3], mem[a+2], mem[a+1], mem[a]} : 32'd0;
  end

  always @(negedge clk) if (rst_n) begin
    if (desc_valid && g_n < 64) begin
      g_off[g_n] = int'(desc_off); g_len[g_n] = int'(desc_len); g_src[g_n] = int'(desc_src);
      g_meta[g_n] = desc_meta; g_keep[g_n] = int'(desc_keep); g_n++;
    end
    if (tag_done) g_td++;
    if (tag_err) g_te++;
    if (overrun) g_ov++;
    if (done) g_done = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nfail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string lbl, input string what, input longint got, input longint exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", lbl, what, got, exp);
    end
  endtask

  function automatic logic [31:0] rdw(int b);
    return {mem[b+3], mem[b+2], mem[b+1], mem[b]};
  endfunction

  function automatic bit op_ok(logic [7:0] op);
    return op == 8'h01 || op == 8'h04 || op == 8'h08 || op == 8'h40;
  endfunction

  function automatic int padded(int len);
    int a;
    a = (cfg_align == 0) ? 1 : cfg_align;
    return ((len + a - 1) / a) * a;
  endfunction

  // independent walk of the buffer bytes
  function automatic void model(int total);
    int off, rem, len, st, src;
    logic [31:0] w0, w1, w3;
    e_n = 0; e_td = 0; e_te = 0; e_ov = 0;
    off = 0; rem = total;
    while (rem >= 32) begin
      w0 = rdw(off); w1 = rdw(off + 4); w3 = rdw(off + 12);
      len = int'(w1[15:0]);
      if (len == 0 || !op_ok(w0[7:0])) begin
        off += 32; rem -= 32;
        continue;
      end
      st = 32 + padded(len) + (cfg_csum ? 8 : 0);
      if (st > rem) begin e_ov = 1; break; end
      src = cfg_wide ? int'(w1[23:16]) : int'(w1[20:16]);
      e_off[e_n] = off + 32; e_len[e_n] = len; e_src[e_n] = src; e_meta[e_n] = rdw(off + 8);
      if (w0[31:16] != 0) begin
        e_keep[e_n] = 0;
        if (src == int'(cfg_cmd)) e_td++; else e_te++;
      end else if (w0[15:8] != 0) e_keep[e_n] = (w0[15:8] != 8'h04);
      else e_keep[e_n] = (w3[31:22] != 10'h3FF);
      e_n++;
      off += st; rem -= st;
    end
  endfunction

  task automatic put32(int b, logic [31:0] v);
    {mem[b+3], mem[b+2], mem[b+1], mem[b]} = v;
  endtask

  task automatic new_buf(int align, bit csum, bit wide, logic [7:0] cmd);
    for (int i = 0; i < MEMB; i++) mem[i] = 8'($urandom);
    cfg_align = align; cfg_csum = csum; cfg_wide = wide; cfg_cmd = cmd; wp = 0;
  endtask

  task automatic add_rec(logic [7:0] op, logic [7:0] exc, logic [15:0] tag, int len,
                         logic [7:0] src, logic [9:0] rule);
    logic [7:0] sf;
    sf = cfg_wide ? src : {3'($urandom), src[4:0]};
    put32(wp, {tag, exc, op});
    put32(wp + 4, {8'($urandom), sf, 16'(len)});
    put32(wp + 8, $urandom);
    put32(wp + 12, {rule, 22'($urandom)});
    if (len == 0 || !op_ok(op)) wp += 32;
    else wp += 32 + padded(len) + (cfg_csum ? 8 : 0);
  endtask

  task automatic run(string lbl, int total, bit poke);
    int t;
    model(total);
    g_n = 0; g_td = 0; g_te = 0; g_ov = 0; g_done = 1'b0;
    @(negedge clk);
    total_len = LEN_W'(total); pad_align = 8'(cfg_align); csum_en = cfg_csum;
    wide_src = cfg_wide; cmd_ep = cfg_cmd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; total_len = '0; pad_align = 8'd64; csum_en = ~cfg_csum;
      wide_src = ~cfg_wide; cmd_ep = ~cfg_cmd;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!g_done && t < 5000) begin @(negedge clk); t++; end
    chk(g_done, lbl, "walk finished", g_done, 1);
    @(negedge clk);
    chk(!busy, lbl, "busy after done", busy, 0);
    chk(g_n == e_n, lbl, "descriptor count", g_n, e_n);
    for (int i = 0; i < e_n && i < g_n; i++) begin
      chk(g_off[i] == e_off[i], {lbl, " R3/R4"}, "offset", g_off[i], e_off[i]);
      chk(g_len[i] == e_len[i] && g_src[i] == e_src[i] && g_meta[i] == e_meta[i],
          {lbl, " R2"}, "len/src/meta", {g_len[i], g_src[i]}, {e_len[i], e_src[i]});
      chk(g_keep[i] == e_keep[i], {lbl, " R7/R8/R9"}, "keep", g_keep[i], e_keep[i]);
    end
    chk(g_td == e_td && g_te == e_te, {lbl, " R7"}, "tag pulses", {g_td, g_te}, {e_td, e_te});
    chk(g_ov == e_ov, {lbl, " R11"}, "overrun", g_ov, e_ov);
  endtask

  initial begin
    int total, nrec, op, len, exc;
    void'($urandom(32'd7013));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !rd_en, "R1", "busy/rd_en at reset", {busy, rd_en}, 0);
    chk(!desc_valid && !done && !overrun && !tag_done && !tag_err, "R1", "pulses at reset", desc_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_en, "R1", "idle after reset", busy, 0);

    // R2 R3 basic narrow layout
    new_buf(0, 0, 0, 8'd5);
    add_rec(8'h01, 0, 0, 5, 8'd3, 10'd1);
    add_rec(8'h40, 0, 0, 12, 8'd7, 10'd2);
    run("R2", wp, 0);
    chk(g_off[0] == 32 && g_len[0] == 5, "R3", "first payload offset", g_off[0], 32);
    chk(g_off[1] == 69, "R4", "unaligned second record", g_off[1], 69);

    // R4 alignment and trailer
    new_buf(4, 1, 0, 8'd5);
    add_rec(8'h01, 0, 0, 5, 8'd1, 10'd1);
    add_rec(8'h08, 0, 0, 3, 8'd2, 10'd1);
    run("R4", wp, 0);
    chk(g_off[1] == 80, "R4", "align 4 plus trailer", g_off[1], 80);
    new_buf(16, 0, 0, 8'd5);
    add_rec(8'h04, 0, 0, 17, 8'd1, 10'd1);
    add_rec(8'h01, 0, 0, 1, 8'd2, 10'd1);
    run("R4", wp, 0);
    chk(g_off[1] == 96, "R4", "align 16", g_off[1], 96);

    // R5 zero length
    new_buf(0, 0, 0, 8'd5);
    add_rec(8'h01, 0, 0, 0, 8'd1, 10'd1);
    add_rec(8'h01, 0, 0, 4, 8'd2, 10'd1);
    run("R5", wp, 0);
    chk(g_n == 1 && g_off[0] == 64, "R5", "zero-length record skipped", g_off[0], 64);

    // R6 foreign opcode
    new_buf(0, 0, 0, 8'd5);
    add_rec(8'h10, 0, 0, 8, 8'd1, 10'd1);
    add_rec(8'h01, 0, 0, 4, 8'd2, 10'd1);
    run("R6", wp, 0);
    chk(g_n == 1 && g_off[0] == 64, "R6", "unknown opcode skipped", g_off[0], 64);

    // R7 tags
    new_buf(0, 0, 0, 8'd5);
    add_rec(8'h01, 0, 16'h0001, 4, 8'd5, 10'd1);
    add_rec(8'h01, 0, 16'h8000, 4, 8'd9, 10'd1);
    run("R7", wp, 0);
    chk(g_td == 1 && g_te == 1 && g_keep[0] == 0, "R7", "tag completion and error", {g_td, g_te}, 17);

    // R8 exceptions, R9 rule miss
    new_buf(0, 0, 0, 8'd5);
    add_rec(8'h01, 8'h04, 0, 4, 8'd1, 10'd1);
    add_rec(8'h01, 8'h02, 0, 4, 8'd1, 10'h3FF);
    add_rec(8'h01, 0, 0, 4, 8'd1, 10'h3FF);
    add_rec(8'h01, 0, 0, 4, 8'd1, 10'd5);
    run("R8", wp, 0);
    chk(g_keep[0] == 0 && g_keep[1] == 1, "R8", "deaggregation drop only", {g_keep[0], g_keep[1]}, 1);
    chk(g_keep[2] == 0 && g_keep[3] == 1, "R9", "rule miss drop", {g_keep[2], g_keep[3]}, 1);

    // R10 short tail
    new_buf(0, 0, 0, 8'd5);
    add_rec(8'h01, 0, 0, 8, 8'd1, 10'd1);
    run("R10", wp + 31, 0);
    chk(g_n == 1 && g_ov == 0, "R10", "tail ignored", g_n, 1);

    // R11 overrun
    new_buf(0, 0, 0, 8'd5);
    add_rec(8'h01, 0, 0, 8, 8'd1, 10'd1);
    add_rec(8'h01, 0, 0, 20, 8'd1, 10'd1);
    run("R11", wp - 1, 0);
    chk(g_n == 1 && g_ov == 1, "R11", "overrun flagged", {g_n, g_ov}, 17);

    // R12 start and config while busy
    new_buf(8, 1, 0, 8'd5);
    add_rec(8'h01, 0, 0, 9, 8'd5, 10'd1);
    add_rec(8'h01, 0, 16'h2, 3, 8'd5, 10'd1);
    add_rec(8'h04, 0, 0, 30, 8'd6, 10'd1);
    run("R12", wp, 1);

    // R2 wide source layout
    new_buf(2, 0, 1, 8'hA5);
    add_rec(8'h01, 0, 0, 7, 8'hC3, 10'd1);
    add_rec(8'h01, 0, 16'h4, 7, 8'hA5, 10'd1);
    run("R2", wp, 0);
    chk(g_src[0] == 'hC3, "R2", "wide source field", g_src[0], 'hC3);

    // random walks
    for (int k = 0; k < 60; k++) begin
      int al[5] = '{0, 1, 2, 4, 16};
      new_buf(al[$urandom % 5], 1'($urandom), 1'($urandom), 8'($urandom % 32));
      nrec = 1 + ($urandom % 6);
      for (int r = 0; r < nrec; r++) begin
        op = ($urandom % 5 == 0) ? 'h20 : int'(8'h01 << (2 * ($urandom % 4)));
        if (op == 'h02) op = 'h04; else if (op == 'h10) op = 'h08;
        len = ($urandom % 10 == 0) ? 0 : 1 + ($urandom % 40);
        exc = ($urandom % 4 == 0) ? (($urandom % 2) ? 'h04 : 'h11) : 0;
        add_rec(8'(op), 8'(exc), ($urandom % 6 == 0) ? 16'(1 + $urandom % 100) : 16'd0, len,
                ($urandom % 2) ? cfg_cmd : 8'($urandom % 32),
                ($urandom % 4 == 0) ? 10'h3FF : 10'($urandom % 1000));
      end
      total = wp + int'($urandom % 40);
      if ($urandom % 6 == 0 && wp > 8) total = wp - 1 - int'($urandom % 8);
      run("R4 R6 R8 R10 random", total, 1'($urandom % 4 == 0));
    end

    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule